// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Look-Ahead Slices

This block compares two unsigned operands and raises exactly one of three flags: the first operand is larger, the second is larger, or both are equal. It is built from 4-bit slices. Each slice finds its most significant differing bit pair and reports which operand holds the 1 there. Each slice also carries a single-wire enable token toward less significant slices, so a decision made high up silences every slice below it without a bit-by-bit ripple.

Inside a slice, the select term for each bit is formed in one flat level of logic. A bit is selected when the slice is enabled, that bit differs, and every more significant bit in the slice matches. The slice passes its token on only when it is enabled itself and all four of its bit pairs match. The top-level wrapper chains the slices from most to least significant. The token of the top slice is tied to the enabling level. The wrapper merges the per-slice outputs with a plain OR, and it ANDs the per-slice equality terms to form the equality flag. The whole block is combinational.

Top module: `cmp_lookahead`

## Requirements
- R1: `a_gt_b` is 1 exactly when unsigned `op_a` is greater than unsigned `op_b`.
- R2: `b_gt_a` is 1 exactly when unsigned `op_b` is greater than unsigned `op_a`.
- R3: `equal` is 1 exactly when `op_a` equals `op_b`, and exactly one of `a_gt_b`, `b_gt_a`, `equal` is 1 for any input.
- R4: In an enabled slice (`la_in`=1), the highest differing bit position, scanning from bit 3 down to bit 0, alone decides the outputs: `gt_a` is 1 if `a` holds the 1 there, and `gt_b` is 1 if `b` does. Both are 0 when no bit differs.
- R5: A slice drives `la_out`=1 only when `la_in`=1 and all four bit pairs are equal.
- R6: A slice with `la_in`=0 drives both `gt_a` and `gt_b` to 0, whatever its operands are. Its `eq` output still reports whether its own four bit pairs match.
- R7: The most significant slice is always enabled. A difference in a more significant slice sets the result no matter what the less significant bits hold, and at most one slice asserts a greater-than output at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| a_gt_b | output | 1 | op_a is greater than op_b |
| b_gt_a | output | 1 | op_b is greater than op_a |
| equal | output | 1 | op_a equals op_b |

## Verification
The bench drives a lone slice through every operand pair, with the token both on and off.

- **Token logic:** a slice that ignored a low `la_in` would assert a greater-than flag even though a more significant slice had already decided. A slice that passed its token on despite a local mismatch would let two slices claim a winner.
- **Operand sweeps:** on the full comparator, the bench walks a single 1 through every bit of each operand. It also places a difference in an upper slice against all-ones opposition below it. A broken priority mask or a mis-ordered chain would let a lower bit overturn the result.
- **Random checks:** random pairs, together with equal pairs, check every flag against the native relational operators.

// File: rtl/cmp_lookahead.sv
module cmp_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         la_in,
  output logic         gt_a,
  output logic         gt_b,
  output logic         la_out,
  output logic         eq
);
  logic [W-1:0] diff;
  logic [W-1:0] sel;

  assign diff = a ^ b;

  for (genvar i = 0; i < W; i++) begin : g_sel
    if (i == W-1) begin : g_top
      assign sel[i] = la_in & diff[i];
    end else begin : g_low
      assign sel[i] = la_in & diff[i] & ~(|diff[W-1:i+1]);
    end
  end

  assign gt_a   = |(sel & a);
  assign gt_b   = |(sel & b);
  assign eq     = ~(|diff);
  assign la_out = la_in & eq;

  always_comb begin
    if (!$isunknown({a, b, la_in})) begin
      p_single_winner_r4: assert (!(gt_a && gt_b));
      p_token_gate_r6:    assert (la_in || (!gt_a && !gt_b));
      p_token_pass_r5:    assert (!la_out || (la_in && a == b));
    end
  end
endmodule

module cmp_lookahead #(
  parameter int SW     = 4,
  parameter int SLICES = 4,
  localparam int W     = SW * SLICES
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         a_gt_b,
  output logic         b_gt_a,
  output logic         equal
);
  logic [SLICES:0]   tok;
  logic [SLICES-1:0] ga, gb, eqs;

  assign tok[SLICES] = 1'b1;

  for (genvar k = SLICES-1; k >= 0; k--) begin : g_slice
    cmp_slice #(.W(SW)) u_slice (
      .a      (op_a[k*SW +: SW]),
      .b      (op_b[k*SW +: SW]),
      .la_in  (tok[k+1]),
      .gt_a   (ga[k]),
      .gt_b   (gb[k]),
      .la_out (tok[k]),
      .eq     (eqs[k])
    );
  end

  assign a_gt_b = |ga;
  assign b_gt_a = |gb;
  assign equal  = &eqs;

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      p_one_flag_r3:     assert ($onehot({a_gt_b, b_gt_a, equal}));
      p_one_slice_r7:    assert ($countones({ga, gb}) <= 1);
      p_eq_vs_token_r3:  assert (equal == tok[0]);
    end
  end
endmodule

// File: tb/cmp_lookahead_bench.sv
module cmp_lookahead_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a, op_b;
  logic        a_gt_b, b_gt_a, equal;
  logic [3:0]  sa, sb;
  logic        sla;
  logic        s_ga, s_gb, s_lo, s_eq;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cmp_lookahead u_cmp_lookahead (
    .op_a(op_a), .op_b(op_b),
    .a_gt_b(a_gt_b), .b_gt_a(b_gt_a), .equal(equal)
  );

  cmp_slice #(.W(4)) u_slice (
    .a(sa), .b(sb), .la_in(sla),
    .gt_a(s_ga), .gt_b(s_gb), .la_out(s_lo), .eq(s_eq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, exp);
    end
  endtask

  task automatic run_top(input logic [15:0] x, input logic [15:0] y, input string tag);
    @(posedge clk);
    op_a = x; op_b = y;
    @(negedge clk);
    chk({tag, " R1"}, a_gt_b, x > y);
    chk({tag, " R2"}, b_gt_a, y > x);
    chk({tag, " R3"}, equal,  x == y);
  endtask

  initial begin
    op_a = '0; op_b = '0; sa = '0; sb = '0; sla = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R3", {a_gt_b, b_gt_a, equal}, 3'b001);

    for (int la = 0; la < 2; la++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(posedge clk);
          sa = 4'(x); sb = 4'(y); sla = 1'(la);
          @(negedge clk);
          if (la == 1) begin
            chk("slice R4 gt_a", s_ga, x > y);
            chk("slice R4 gt_b", s_gb, y > x);
          end else begin
            chk("slice R6 gt_a", s_ga, 0);
            chk("slice R6 gt_b", s_gb, 0);
          end
          chk("slice R5 la_out", s_lo, (la == 1) && (x == y));
          chk("slice R6 eq", s_eq, x == y);
        end
      end
    end

    for (int i = 0; i < 16; i++) begin
      run_top(16'(1) << i, 16'h0000, "walk");
      run_top(16'h0000, 16'(1) << i, "walk");
      run_top(~(16'(1) << i), 16'hffff, "walk0");
    end

    for (int k = 1; k < 4; k++) begin
      for (int n = 0; n < 64; n++) begin
        logic [15:0] hi_a, hi_b, r;
        r = 16'($urandom);
        hi_a = r | (16'(1) << (4*k));
        hi_b = r & ~(16'(1) << (4*k));
        hi_a = (hi_a >> (4*k)) << (4*k);
        hi_b = (hi_b >> (4*k)) << (4*k) | ((16'(1) << (4*k)) - 16'(1));
        run_top(hi_a, hi_b, "R7 upper");
        run_top(hi_b, hi_a, "R7 upper");
      end
    end

    run_top(16'hffff, 16'hffff, "edge");
    run_top(16'hffff, 16'h0000, "edge");
    run_top(16'h0000, 16'hffff, "edge");
    run_top(16'h8000, 16'h7fff, "edge");

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = (n % 5 == 0) ? x : 16'($urandom);
      run_top(x, y, "rand");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule